// File: doc/BRIEF.md
# Scratch RAM, Parallel Port and Interval Timer Peripheral

This block hangs off the bus of an 8-bit processor. It holds three functions behind one chip select: 128 bytes of scratch memory, two 8-bit parallel ports whose direction is set bit by bit, and an 8-bit interval timer. The timer counts down through a prescaler chosen when it is loaded. Bit 7 of port A also feeds an edge detector that can raise an interrupt. The `reg_sel` input picks between the memory and the register bank.

Only five low address bits reach the register bank, so most registers answer at several addresses. Some address bits act as control fields. A timer load picks the prescale divisor and the timer interrupt enable from the address it is written to. An edge-control write picks the polarity and the interrupt enable of the port A bit 7 detector in the same way.

The bus is a plain one-cycle interface with no valid/ready handshake and no back-pressure. A cycle with `cs` high is one access. A write takes effect at that clock edge. Read data appears on `rdata` after that edge and holds until the next read. Port pins appear as separate input, output and output-enable vectors.

Top module: `ram_io_timer`

## Requirements
- R1: With `reg_sel` low, an access reaches the 128-byte memory at `addr[6:0]`. A write stores `wdata` there, and a read returns the stored byte on `rdata` after the access edge.
- R2: With `reg_sel` high and `addr[2]` low, `addr[1:0]` picks the port register: 0 is port A data, 1 is port A direction, 2 is port B data, 3 is port B direction. `addr[6:3]` has no effect on this choice.
- R3: A port drives each pin from its data latch, and enables the pin only where its direction bit is 1. A read of a port data register returns the pin input on direction-0 bits and the latch on direction-1 bits.
- R4: A write with `reg_sel` high, `addr[4]` low and `addr[2]` high sets up the port A bit 7 detector. `addr[0]` picks the edge (0 falling, 1 rising) and `addr[1]` sets its interrupt enable. After reset the detector uses the falling edge with its interrupt off.
- R5: The selected edge on `pa_in[7]` sets the edge flag, which is bit 6 of the flag register. A read of the flag register (`reg_sel` high, `addr[2]` high, `addr[0]` high, read) clears the edge flag and returns the value from before the clear.
- R6: A write with `reg_sel` high, `addr[4]` high and `addr[2]` high loads `wdata` into the timer. `addr[1:0]` picks the divisor (0: 1, 1: 8, 2: 64, 3: 1024) and `addr[3]` sets the timer interrupt enable.
- R7: After a load of N at edge W, a timer read (`addr[2]` high, `addr[0]` low, read) at edge W+k returns N minus floor((k-1)/divisor), for as long as the count stays at or above 0.
- R8: When the timer steps past zero it wraps to 0xFF and sets the timer flag, which is bit 7 of the flag register. From then on it decrements on every clock until the next load.
- R9: A timer read or a timer load clears the timer flag, and a flag-register read does not. A timer read also copies `addr[3]` into the timer interrupt enable.
- R10: `irq_n` is low exactly while a flag is set whose interrupt enable is on.
- R11: Reset clears the port latches, the directions, both flags, both enables and `rdata`, and drives `irq_n` high. The timer then reads 0 and stays stopped, with no flag, until its first load.
- R12: While `cs` is low, no memory or register changes and `rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs | input | 1 | Access strobe for this cycle |
| reg_sel | input | 1 | 1 selects the register bank, 0 selects the memory |
| wr | input | 1 | 1 for a write, 0 for a read |
| addr | input | 7 | Address; register decode uses bits 4..0 |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| irq_n | output | 1 | Interrupt request, active low |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A pin output values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B pin output values |
| pb_oe | output | 8 | Port B output enables |

## Verification
The bench builds the block with its default parameters: 8-bit data, ports and timer, and a 7-bit memory address. With these values the bench can load a count under every divisor, including 1024, and read it on both sides of the first prescaled decrement. It also reaches the memory's top and bottom bytes and the register mirrors that upper address bits create. An underflow under the divisor of 1 shows the wrap to 0xFF and the fast count after it within a few cycles.

// File: rtl/ram_io_pkg.sv
package ram_io_pkg;

  typedef enum logic [1:0] {
    PS_DIV1    = 2'd0,
    PS_DIV8    = 2'd1,
    PS_DIV64   = 2'd2,
    PS_DIV1024 = 2'd3
  } prescale_e;

  localparam int PRESC_W = 10;

  // last prescaler count before a decrement step
  function automatic logic [PRESC_W-1:0] presc_limit(prescale_e sel);
    case (sel)
      PS_DIV1:  return PRESC_W'(0);
      PS_DIV8:  return PRESC_W'(7);
      PS_DIV64: return PRESC_W'(63);
      default:  return PRESC_W'(1023);
    endcase
  endfunction

  typedef struct packed {
    logic ram_wr;
    logic port_acc;
    logic edge_wr;
    logic tmr_wr;
    logic tmr_rd;
    logic flag_rd;
    logic rd;
  } bus_op_t;

endpackage

// File: rtl/ram_io_scratch.sv
module ram_io_scratch #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/ram_io_port.sv
module ram_io_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         data_wr,
  input  logic         dir_wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] data_rd,
  output logic [W-1:0] dir_rd
);
  logic [W-1:0] latch_q;
  logic [W-1:0] dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else begin
      if (data_wr) latch_q <= wdata;
      if (dir_wr)  dir_q   <= wdata;
    end
  end

  assign pin_out = latch_q;
  assign pin_oe  = dir_q;
  assign data_rd = (pin_in & ~dir_q) | (latch_q & dir_q);
  assign dir_rd  = dir_q;
endmodule

// File: rtl/ram_io_edge.sv
module ram_io_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  logic cfg_rising,
  input  logic cfg_ien,
  input  logic pin,
  input  logic clr,
  output logic flag,
  output logic ien
);
  logic prev_q;
  logic rising_q;
  logic hit;

  assign hit = rising_q ? (!prev_q && pin) : (prev_q && !pin);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      rising_q <= 1'b0;
      ien      <= 1'b0;
      flag     <= 1'b0;
    end else begin
      prev_q <= pin;
      if (cfg_wr) begin
        rising_q <= cfg_rising;
        ien      <= cfg_ien;
      end
      if (clr) flag <= 1'b0;
      if (hit) flag <= 1'b1;
    end
  end
endmodule

// File: rtl/ram_io_tmr.sv
module ram_io_tmr
  import ram_io_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  prescale_e     load_sel,
  input  logic [DW-1:0] load_val,
  input  logic          rd,
  input  logic          ien_val,
  output logic [DW-1:0] count,
  output logic          flag,
  output logic          ien
);
  prescale_e          sel_q;
  logic [PRESC_W-1:0] presc_q;
  logic               run_q;
  logic               fast_q;
  logic               at_limit;
  logic               tick;
  logic               wrap;

  assign at_limit = (presc_q == presc_limit(sel_q));
  assign tick     = run_q && (fast_q || at_limit);
  assign wrap     = tick && (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= PS_DIV1;
      presc_q <= '0;
      run_q   <= 1'b0;
      fast_q  <= 1'b0;
      count   <= '0;
      flag    <= 1'b0;
      ien     <= 1'b0;
    end else if (load) begin
      sel_q   <= load_sel;
      presc_q <= '0;
      run_q   <= 1'b1;
      fast_q  <= 1'b0;
      count   <= load_val;
      flag    <= 1'b0;
      ien     <= ien_val;
    end else begin
      if (run_q) presc_q <= at_limit ? '0 : presc_q + 1'b1;
      if (rd) begin
        flag <= 1'b0;
        ien  <= ien_val;
      end
      if (tick) count <= count - 1'b1;
      if (wrap) begin
        flag   <= 1'b1;
        fast_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ram_io_timer.sv
module ram_io_timer
  import ram_io_pkg::*;
#(
  parameter int RAM_AW = 7,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              reg_sel,
  input  logic              wr,
  input  logic [RAM_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              irq_n,
  input  logic [DW-1:0]     pa_in,
  output logic [DW-1:0]     pa_out,
  output logic [DW-1:0]     pa_oe,
  input  logic [DW-1:0]     pb_in,
  output logic [DW-1:0]     pb_out,
  output logic [DW-1:0]     pb_oe
);
  localparam int NPORT = 2;

  bus_op_t       op;
  logic [DW-1:0] ram_q;
  logic [DW-1:0] p_in   [NPORT];
  logic [DW-1:0] p_out  [NPORT];
  logic [DW-1:0] p_oe   [NPORT];
  logic [DW-1:0] p_rd   [NPORT];
  logic [DW-1:0] p_dir  [NPORT];
  logic [DW-1:0] tmr_count;
  logic          tmr_flag;
  logic          tmr_ien;
  logic          pa7_flag;
  logic          pa7_ien;
  logic [DW-1:0] flag_reg;
  logic [DW-1:0] rd_next;

  // access decode
  always_comb begin
    op          = '0;
    op.rd       = cs && !wr;
    op.ram_wr   = cs && !reg_sel && wr;
    op.port_acc = cs && reg_sel && !addr[2];
    op.edge_wr  = cs && reg_sel && addr[2] && !addr[4] && wr;
    op.tmr_wr   = cs && reg_sel && addr[2] && addr[4] && wr;
    op.tmr_rd   = cs && reg_sel && addr[2] && !addr[0] && !wr;
    op.flag_rd  = cs && reg_sel && addr[2] && addr[0] && !wr;
  end

  ram_io_scratch #(.AW(RAM_AW), .DW(DW)) u_ram (
    .clk   (clk),
    .we    (op.ram_wr),
    .addr  (addr),
    .wdata (wdata),
    .rdata (ram_q)
  );

  assign p_in[0] = pa_in;
  assign p_in[1] = pb_in;
  assign pa_out  = p_out[0];
  assign pa_oe   = p_oe[0];
  assign pb_out  = p_out[1];
  assign pb_oe   = p_oe[1];

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    logic hit;
    assign hit = op.port_acc && wr && (addr[1] == 1'(g));
    ram_io_port #(.W(DW)) u_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .data_wr (hit && !addr[0]),
      .dir_wr  (hit && addr[0]),
      .wdata   (wdata),
      .pin_in  (p_in[g]),
      .pin_out (p_out[g]),
      .pin_oe  (p_oe[g]),
      .data_rd (p_rd[g]),
      .dir_rd  (p_dir[g])
    );
  end

  ram_io_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (op.edge_wr),
    .cfg_rising (addr[0]),
    .cfg_ien    (addr[1]),
    .pin        (pa_in[DW-1]),
    .clr        (op.flag_rd),
    .flag       (pa7_flag),
    .ien        (pa7_ien)
  );

  ram_io_tmr #(.DW(DW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (op.tmr_wr),
    .load_sel (prescale_e'(addr[1:0])),
    .load_val (wdata),
    .rd       (op.tmr_rd),
    .ien_val  (addr[3]),
    .count    (tmr_count),
    .flag     (tmr_flag),
    .ien      (tmr_ien)
  );

  assign flag_reg = {tmr_flag, pa7_flag, {(DW-2){1'b0}}};

  // read data select
  always_comb begin
    if (!reg_sel) begin
      rd_next = ram_q;
    end else if (!addr[2]) begin
      case (addr[1:0])
        2'd0:    rd_next = p_rd[0];
        2'd1:    rd_next = p_dir[0];
        2'd2:    rd_next = p_rd[1];
        default: rd_next = p_dir[1];
      endcase
    end else if (addr[0]) begin
      rd_next = flag_reg;
    end else begin
      rd_next = tmr_count;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (op.rd) rdata <= rd_next;
  end

  assign irq_n = !((tmr_flag && tmr_ien) || (pa7_flag && pa7_ien));
endmodule

// File: rtl/ram_io_timer_chk.sv
module ram_io_timer_chk #(
  parameter int RAM_AW = 7,
  parameter int DW     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs,
  input logic              reg_sel,
  input logic              wr,
  input logic [RAM_AW-1:0] addr,
  input logic [DW-1:0]     wdata,
  input logic [DW-1:0]     rdata,
  input logic              irq_n,
  input logic [DW-1:0]     pa_out,
  input logic [DW-1:0]     pa_oe,
  input logic              tmr_flag,
  input logic              pa7_flag
);
  logic wr_reg;
  assign wr_reg = cs && reg_sel && wr;

  AST_PORTA_DATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_reg && addr[2:0] == 3'd0) |=> (pa_out == $past(wdata))); // R2

  AST_PORTA_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_reg && addr[2:0] == 3'd1) |=> (pa_oe == $past(wdata))); // R3

  AST_TMR_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_reg && addr[2] && addr[4]) |=> !tmr_flag); // R9

  AST_IDLE_HOLDS_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> $stable(rdata)); // R12

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (irq_n && pa_oe == '0 && !tmr_flag && !pa7_flag)); // R11

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (tmr_flag || pa7_flag)); // R10
endmodule

bind ram_io_timer ram_io_timer_chk #(.RAM_AW(RAM_AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs       (cs),
  .reg_sel  (reg_sel),
  .wr       (wr),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .irq_n    (irq_n),
  .pa_out   (pa_out),
  .pa_oe    (pa_oe),
  .tmr_flag (tmr_flag),
  .pa7_flag (pa7_flag)
);

// File: tb/test_ram_io_timer.sv
module test_ram_io_timer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0;
  logic       reg_sel = 1'b0;
  logic       wr = 1'b0;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_n;
  logic [7:0] pa_in = '0;
  logic [7:0] pa_out, pa_oe;
  logic [7:0] pb_in = '0;
  logic [7:0] pb_out, pb_oe;

  int compared = 0;
  int mismatched = 0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;
  exp_t sb[$];
  logic rd_issued = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ram_io_timer i_ram_io_timer (
    .clk(clk), .rst_n(rst_n), .cs(cs), .reg_sel(reg_sel), .wr(wr),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: a read issued at an edge is compared at the following negedge
  always @(posedge clk) rd_issued <= rst_n && cs && !wr;
  always @(negedge clk) begin
    if (rd_issued) begin
      if (sb.size() == 0) begin
        check("scoreboard underrun", rdata, 8'h00);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, rdata, e.val);
      end
    end
  end

  task automatic acc(input logic rs, input logic w, input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; reg_sel = rs; wr = w; addr = a; wdata = d;
    @(posedge clk);
  endtask

  task automatic wrt(input logic rs, input logic [6:0] a, input logic [7:0] d);
    acc(rs, 1'b1, a, d);
  endtask

  task automatic rd(input logic rs, input logic [6:0] a, input logic [7:0] exp, input string tag);
    exp_t e;
    e.val = exp; e.tag = tag;
    sb.push_back(e);
    acc(rs, 1'b0, a, 8'h00);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cs = 1'b0; wr = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    idle(4);
    // R11 reset state
    check("R11 irq_n after reset", {7'd0, irq_n}, 8'h01);
    check("R11 pa_oe after reset", pa_oe, 8'h00);
    check("R11 pb_oe after reset", pb_oe, 8'h00);
    check("R11 pa_out after reset", pa_out, 8'h00);
    check("R11 rdata after reset", rdata, 8'h00);
    rd(1'b1, 7'h04, 8'h00, "R11 timer stopped at 0");
    rd(1'b1, 7'h05, 8'h00, "R11 flags clear");

    // R1 memory
    wrt(1'b0, 7'h00, 8'h11);
    wrt(1'b0, 7'h7F, 8'h22);
    wrt(1'b0, 7'h40, 8'h33);
    rd(1'b0, 7'h00, 8'h11, "R1 ram low");
    rd(1'b0, 7'h7F, 8'h22, "R1 ram top");
    rd(1'b0, 7'h40, 8'h33, "R1 ram mid");

    // R2/R3 ports and mirrors
    pa_in = 8'h3C;
    wrt(1'b1, 7'h01, 8'hF0);
    wrt(1'b1, 7'h00, 8'hA5);
    wrt(1'b1, 7'h1A, 8'h5A);
    wrt(1'b1, 7'h6B, 8'hFF);
    idle(1);
    check("R3 pa_oe from direction", pa_oe, 8'hF0);
    check("R3 pa_out from latch", pa_out, 8'hA5);
    check("R2 pb_oe via mirror", pb_oe, 8'hFF);
    rd(1'b1, 7'h00, 8'hAC, "R3 port A mixed read");
    rd(1'b1, 7'h02, 8'h5A, "R2 port B data mirror");
    rd(1'b1, 7'h0B, 8'hFF, "R2 port B direction mirror");
    rd(1'b1, 7'h11, 8'hF0, "R2 port A direction mirror");
    rd(1'b0, 7'h00, 8'h11, "R1 ram apart from port A data");

    // R12 cs low ignored
    idle(1);
    reg_sel = 1'b0; wr = 1'b1; addr = 7'h00; wdata = 8'h99;
    @(negedge clk);
    check("R12 rdata held while idle", rdata, 8'h11);
    rd(1'b0, 7'h00, 8'h11, "R12 ram unchanged");

    // R4/R5 port A bit 7 edge
    pa_in = 8'h00;
    idle(2);
    pa_in[7] = 1'b1;
    idle(3);
    rd(1'b1, 7'h05, 8'h00, "R5 rising ignored on falling setting");
    pa_in[7] = 1'b0;
    idle(3);
    check("R4 edge irq off after reset", {7'd0, irq_n}, 8'h01);
    rd(1'b1, 7'h05, 8'h40, "R5 falling edge flag");
    rd(1'b1, 7'h0D, 8'h00, "R5 flag read clears");
    wrt(1'b1, 7'h47, 8'h00);
    idle(1);
    pa_in[7] = 1'b1;
    idle(3);
    check("R10 irq on rising edge enabled", {7'd0, irq_n}, 8'h00);
    rd(1'b1, 7'h05, 8'h40, "R4 rising edge flag");
    idle(1);
    check("R10 irq released after flag read", {7'd0, irq_n}, 8'h01);

    // R6/R7 timer divisors
    wrt(1'b1, 7'h14, 8'd5);
    rd(1'b1, 7'h04, 8'd5, "R7 div1 k=1");
    idle(2);
    rd(1'b1, 7'h04, 8'd2, "R7 div1 k=4");
    wrt(1'b1, 7'h15, 8'd10);
    idle(8);
    rd(1'b1, 7'h04, 8'd9, "R7 div8 k=9");
    idle(7);
    rd(1'b1, 7'h04, 8'd8, "R7 div8 k=17");
    wrt(1'b1, 7'h16, 8'd3);
    idle(63);
    rd(1'b1, 7'h04, 8'd3, "R7 div64 k=64");
    rd(1'b1, 7'h04, 8'd2, "R7 div64 k=65");
    wrt(1'b1, 7'h17, 8'd1);
    idle(1023);
    rd(1'b1, 7'h04, 8'd1, "R6 div1024 k=1024");
    rd(1'b1, 7'h04, 8'd0, "R6 div1024 k=1025");

    // R8 underflow with interrupt enabled
    wrt(1'b1, 7'h1C, 8'd2);
    idle(4);
    rd(1'b1, 7'h05, 8'h80, "R8 timer flag after wrap");
    idle(1);
    check("R10 irq from timer", {7'd0, irq_n}, 8'h00);
    rd(1'b1, 7'h0C, 8'hFC, "R8 fast count after wrap");
    idle(1);
    check("R9 irq released by timer read", {7'd0, irq_n}, 8'h01);
    rd(1'b1, 7'h05, 8'h00, "R9 timer flag cleared by read");

    // R9 read with addr[3]=0 drops the enable
    wrt(1'b1, 7'h1C, 8'd1);
    rd(1'b1, 7'h04, 8'd1, "R9 read disabling enable");
    idle(3);
    rd(1'b1, 7'h05, 8'h80, "R9 flag not cleared by flag read");
    idle(1);
    check("R9 irq stays high with enable off", {7'd0, irq_n}, 8'h01);
    rd(1'b1, 7'h05, 8'h80, "R9 flag still set");
    wrt(1'b1, 7'h17, 8'h50);
    rd(1'b1, 7'h05, 8'h00, "R9 load clears timer flag");

    idle(3);
    finish_run();
  end
endmodule